// File: doc/BRIEF.md
# DPLL Mode and Holdover Controller

This block is the control and frequency-memory section of a digital PLL that serves four timing references. Software programs an operating mode and a reference index; external monitors report per-reference quality flags; the loop filter presents its current frequency-offset word every cycle. The block decides which reference is active, reports the effective state, and produces the frequency word that drives the numerically controlled oscillator.

While locked, the block copies the tracked frequency into a small ring of history entries at a fixed cycle interval. A reference usually goes bad some time before the monitors flag it, and the loop tracks the bad signal in the meantime. On entry to holdover the block therefore does not use the most recent sample. It restores an older entry that predates the failure. In automatic mode the block moves between locked and holdover by itself, based on the quality flags and a preferred reference.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rstN` is low, and at the first edge after it rises, `effState` reads 4 (reset), `freqOut` reads 0 and `activeRef` reads 0.
- R2: With `modeSel`=0 (locked to a forced reference), `effState` becomes 0 and `activeRef` becomes `refSel` one edge later, whatever `refValid` holds. From then on, `freqOut` after each edge equals the `trackFreq` value present at that edge.
- R3: With `modeSel`=1 (holdover), `effState` becomes 1 and `freqOut` stays constant for as long as the state remains holdover, whatever `trackFreq` does.
- R4: On each `SAMPLE_INTERVAL`-th consecutive edge at which the registered state is locked (0), the history ring stores the `trackFreq` present at that edge.
- R5: At the edge that enters holdover, `freqOut` takes the history entry written `RESTORE_AGE` (default 2) writes before the most recent write. Entries that were never written read as 0.
- R6: The history ring and the interval counter do not advance while the registered state is holdover, free-run or reset.
- R7: With `modeSel`=3, or any code from 5 to 7, `effState` becomes 3 and `freqOut` becomes 0 (nominal frequency).
- R8: With `modeSel`=4 (internal reset), `effState` becomes 4, and `freqOut` and `activeRef` become 0. Every history entry and the interval counter are cleared.
- R9: With `modeSel`=2 (automatic), if `refValid[refSel]` is 1, the next state is locked with `activeRef`=`refSel`.
- R10: In automatic mode, when the preferred reference is invalid but another is valid, the lowest-indexed valid reference becomes active and the state is locked.
- R11: In automatic mode, when `refValid` is 0, the state becomes holdover and `activeRef` keeps its value. The state returns to locked at the edge after any flag becomes 1.
- R12: One edge after `modeSel`=2 is sampled, `effState` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Programmed mode: 0 locked, 1 holdover, 2 automatic, 3 free-run, 4 internal reset, 5-7 free-run |
| refSel | input | 2 | Forced reference (mode 0) or preferred reference (mode 2) |
| refValid | input | 4 | Per-reference quality flag from the monitors, bit n for reference n |
| trackFreq | input | FREQ_W | Frequency-offset word tracked by the loop |
| activeRef | output | 2 | Index of the active reference |
| effState | output | 3 | Effective state, using the same codes as modeSel |
| freqOut | output | FREQ_W | Frequency word sent to the oscillator |

## Verification
The bench feeds a staircase of `trackFreq` values that changes once per sampling interval. A restore that returns any value but the one two writes back therefore shows which entry, or which interval, was wrong. A second holdover entry after a long holdover stay tells a frozen history apart from one that kept writing. A restore of zero after internal reset shows that the clear took effect. In automatic mode, the bench first drives all references valid, then removes the preferred one, then a lower one, then all of them, and finally restores a single one. This separates preference, lowest-index fallback and the holdover round trip. A forced lock to an invalid reference shows that forced selection ignores quality.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0,
    ST_HOLD = 3'd1,
    ST_AUTO = 3'd2,
    ST_FREE = 3'd3,
    ST_RST  = 3'd4
  } dpll_state_e;

  typedef enum logic [1:0] {
    SEL_TRACK = 2'd0,
    SEL_KEEP  = 2'd1,
    SEL_ZERO  = 2'd2
  } freq_sel_e;

  typedef struct packed {
    logic      sampleEn;
    logic      clearHist;
    logic      enterHold;
    freq_sel_e freqSel;
  } ctrl_strobe_t;

  function automatic logic [1:0] lowestValid(input logic [3:0] flags);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (flags[i]) idx = 2'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
#(
  parameter int NUM_REFS = 4,
  localparam int REF_W = $clog2(NUM_REFS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          modeSel,
  input  logic [REF_W-1:0]    refSel,
  input  logic [NUM_REFS-1:0] refValid,
  output logic [REF_W-1:0]    activeRef,
  output dpll_state_e         curState,
  output ctrl_strobe_t        strobe
);

  dpll_state_e      nxtState;
  logic [REF_W-1:0] nxtRef;

  always_comb begin
    nxtState = ST_FREE;
    nxtRef   = activeRef;
    unique case (modeSel)
      3'd0: begin
        nxtState = ST_LOCK;
        nxtRef   = refSel;
      end
      3'd1: nxtState = ST_HOLD;
      3'd2: begin
        if (refValid[refSel]) begin
          nxtState = ST_LOCK;
          nxtRef   = refSel;
        end else if (|refValid) begin
          nxtState = ST_LOCK;
          nxtRef   = lowestValid(refValid);
        end else begin
          nxtState = ST_HOLD;
        end
      end
      3'd4: begin
        nxtState = ST_RST;
        nxtRef   = '0;
      end
      default: nxtState = ST_FREE;
    endcase
  end

  always_comb begin
    strobe.sampleEn  = (curState == ST_LOCK);
    strobe.clearHist = (nxtState == ST_RST);
    strobe.enterHold = (nxtState == ST_HOLD) && (curState != ST_HOLD);
    unique case (nxtState)
      ST_LOCK: strobe.freqSel = SEL_TRACK;
      ST_HOLD: strobe.freqSel = SEL_KEEP;
      default: strobe.freqSel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState  <= ST_RST;
      activeRef <= '0;
    end else begin
      curState  <= nxtState;
      activeRef <= nxtRef;
    end
  end

endmodule

// File: rtl/dpll_holdover_dp.sv
module dpll_holdover_dp
  import dpll_mode_pkg::*;
#(
  parameter int FREQ_W          = 16,
  parameter int HIST_DEPTH      = 4,
  parameter int SAMPLE_INTERVAL = 8,
  parameter int RESTORE_AGE     = 2,
  localparam int PTR_W = $clog2(HIST_DEPTH),
  localparam int CNT_W = $clog2(SAMPLE_INTERVAL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [FREQ_W-1:0] trackFreq,
  output logic [FREQ_W-1:0] freqOut
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_INTERVAL - 1);
  localparam logic [PTR_W-1:0] AGE_OFS  = PTR_W'(RESTORE_AGE + 1);

  logic [CNT_W-1:0]  intervalCnt;
  logic [PTR_W-1:0]  wrPtr;
  logic              writeNow;
  logic [FREQ_W-1:0] histMem [HIST_DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [FREQ_W-1:0] restoreVal;

  assign writeNow   = strobe.sampleEn && !strobe.clearHist && (intervalCnt == CNT_LAST);
  assign rdPtr      = wrPtr - AGE_OFS;
  assign restoreVal = histMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
      wrPtr       <= '0;
    end else if (strobe.clearHist) begin
      intervalCnt <= '0;
      wrPtr       <= '0;
    end else if (strobe.sampleEn) begin
      if (intervalCnt == CNT_LAST) begin
        intervalCnt <= '0;
        wrPtr       <= wrPtr + 1'b1;
      end else begin
        intervalCnt <= intervalCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        histMem[g] <= '0;
      end else if (strobe.clearHist) begin
        histMem[g] <= '0;
      end else if (writeNow && (wrPtr == PTR_W'(g))) begin
        histMem[g] <= trackFreq;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqOut <= '0;
    end else begin
      unique case (strobe.freqSel)
        SEL_TRACK: freqOut <= trackFreq;
        SEL_KEEP:  freqOut <= strobe.enterHold ? restoreVal : freqOut;
        default:   freqOut <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int FREQ_W          = 16,
  parameter int HIST_DEPTH      = 4,
  parameter int SAMPLE_INTERVAL = 8,
  parameter int RESTORE_AGE     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic [1:0]        refSel,
  input  logic [3:0]        refValid,
  input  logic [FREQ_W-1:0] trackFreq,
  output logic [1:0]        activeRef,
  output logic [2:0]        effState,
  output logic [FREQ_W-1:0] freqOut
);

  dpll_state_e  curState;
  ctrl_strobe_t strobe;

  dpll_mode_fsm #(.NUM_REFS(4)) uFsm (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refSel(refSel),
    .refValid(refValid), .activeRef(activeRef), .curState(curState),
    .strobe(strobe)
  );

  dpll_holdover_dp #(
    .FREQ_W(FREQ_W), .HIST_DEPTH(HIST_DEPTH),
    .SAMPLE_INTERVAL(SAMPLE_INTERVAL), .RESTORE_AGE(RESTORE_AGE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trackFreq(trackFreq),
    .freqOut(freqOut)
  );

  assign effState = curState;

endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk #(
  parameter int FREQ_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeSel,
  input logic [1:0]        refSel,
  input logic [3:0]        refValid,
  input logic [FREQ_W-1:0] trackFreq,
  input logic [1:0]        activeRef,
  input logic [2:0]        effState,
  input logic [FREQ_W-1:0] freqOut
);

  assert_lock_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0) |=> (effState == 3'd0 && freqOut == $past(trackFreq)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (effState == 3'd1 && modeSel == 3'd1) |=> $stable(freqOut));

  assert_free_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd3) |=> (effState == 3'd3 && freqOut == '0));

  assert_reset_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd4) |=> (effState == 3'd4 && freqOut == '0 && activeRef == 2'd0));

  assert_auto_pref_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd2 && refValid[refSel]) |=> (effState == 3'd0 && activeRef == $past(refSel)));

  assert_auto_none_R11: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd2 && refValid == 4'd0) |=> (effState == 3'd1 && $stable(activeRef)));

  assert_auto_states_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd2) |=> (effState == 3'd0 || effState == 3'd1));

endmodule

bind dpll_mode_ctrl dpll_mode_chk #(.FREQ_W(FREQ_W)) uChk (.*);

// File: tb/tb_dpll_mode_ctrl.sv
module tb_dpll_mode_ctrl;

  localparam int FW = 16;
  localparam int IV = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    modeSel = 3'd4;
  logic [1:0]    refSel = 2'd0;
  logic [3:0]    refValid = 4'd0;
  logic [FW-1:0] trackFreq = '0;
  logic [1:0]    activeRef;
  logic [2:0]    effState;
  logic [FW-1:0] freqOut;

  int checks = 0;
  int errors = 0;
  logic [FW-1:0] stair [6];

  dpll_mode_ctrl #(.FREQ_W(FW), .SAMPLE_INTERVAL(IV)) dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refSel(refSel),
    .refValid(refValid), .trackFreq(trackFreq), .activeRef(activeRef),
    .effState(effState), .freqOut(freqOut)
  );

  always #10 clk = ~clk;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    checkEq("R1", "state in reset", effState, 4);
    checkEq("R1", "freq in reset", freqOut, 0);
    checkEq("R1", "ref in reset", activeRef, 0);
    rstN = 1'b1;
    step(1);
    checkEq("R1", "state after release", effState, 4);
    checkEq("R1", "freq after release", freqOut, 0);
  endtask

  task automatic testLockAndRestore();
    for (int k = 0; k < 6; k++) stair[k] = FW'(16'h1000 + 16'h0111 * k);
    modeSel = 3'd0; refSel = 2'd2; refValid = 4'd0;
    step(1);
    checkEq("R2", "forced state", effState, 0);
    checkEq("R2", "forced ref ignores flags", activeRef, 2);
    for (int k = 0; k < 6; k++) begin
      trackFreq = stair[k];
      step(IV);
      checkEq("R2", "freq follows track", freqOut, int'(stair[k]));
    end
    modeSel = 3'd1; trackFreq = 16'h7777;
    step(1);
    checkEq("R3", "hold state", effState, 1);
    checkEq("R5", "restored two writes back (R4 interval)", freqOut, int'(stair[3]));
    trackFreq = 16'h2222;
    step(30);
    checkEq("R3", "hold freq steady", freqOut, int'(stair[3]));
    modeSel = 3'd0; trackFreq = 16'h0abc;
    step(1);
    checkEq("R2", "relock freq", freqOut, 16'h0abc);
    modeSel = 3'd1;
    step(1);
    checkEq("R6", "history frozen during hold", freqOut, int'(stair[3]));
  endtask

  task automatic testFreeAndReset();
    modeSel = 3'd3;
    step(1);
    checkEq("R7", "free state", effState, 3);
    checkEq("R7", "free freq", freqOut, 0);
    modeSel = 3'd6;
    step(1);
    checkEq("R7", "code 6 free", effState, 3);
    modeSel = 3'd4;
    step(1);
    checkEq("R8", "reset state", effState, 4);
    checkEq("R8", "reset ref", activeRef, 0);
    checkEq("R8", "reset freq", freqOut, 0);
    modeSel = 3'd0; refSel = 2'd1; trackFreq = 16'h0555;
    step(1);
    modeSel = 3'd1;
    step(1);
    checkEq("R8", "restore after clear", freqOut, 0);
  endtask

  task automatic testAuto();
    modeSel = 3'd2; refSel = 2'd1; refValid = 4'b1111; trackFreq = 16'h0321;
    step(1);
    checkEq("R9", "preferred ref", activeRef, 1);
    checkEq("R12", "auto state locked", effState, 0);
    refValid = 4'b1101;
    step(1);
    checkEq("R10", "lowest valid", activeRef, 0);
    refValid = 4'b1100;
    step(1);
    checkEq("R10", "lowest valid above", activeRef, 2);
    refValid = 4'b0000; trackFreq = 16'h0999;
    step(1);
    checkEq("R11", "none valid hold", effState, 1);
    checkEq("R11", "ref kept", activeRef, 2);
    checkEq("R11", "restored cleared entry", freqOut, 0);
    step(3);
    checkEq("R12", "auto state hold", effState, 1);
    refValid = 4'b1000; trackFreq = 16'h0444;
    step(1);
    checkEq("R11", "back to lock", effState, 0);
    checkEq("R11", "new ref", activeRef, 3);
    checkEq("R11", "freq tracks again", freqOut, 16'h0444);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    testReset();
    testLockAndRestore();
    testFreeAndReset();
    testAuto();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule